// File: doc/BRIEF.md
# SHA Message Stream Padder

This block sits in front of a SHA compression core. A request on `start` while the block is idle captures a 64-bit message length, counted in bits. The block then takes 32-bit message words from an upstream source through a valid/enable handshake and passes them downstream through a valid/ready handshake. In each word the earliest message bit sits at bit 31.

When the message ends, the block appends the SHA padding. This is a single 1 bit right after the last message bit, then zero fill, then the 64-bit length in the final two words of the last 512-bit block. If the message ends part-way through a word, the unused low bits of that word are overwritten. If the padding does not fit, it spills into one more block.

Every output word carries two flags. One marks the 16th word of each block. The other marks the closing word of the whole padded message. The block is a single module. Input acceptance is tied directly to downstream readiness, so no word is held inside the block.

Top module: `sha_stream_padder`

## Requirements
- R1: After reset the block is idle. While idle, `in_ready` and `out_valid` stay low.
- R2: `bit_len` is captured only by `start` while idle. While active, `start` and changes on `bit_len` have no effect on the output stream.
- R3: A message word is taken only when `in_valid`, `in_ready` and `out_ready` are all high. A word whose 32 bits all lie inside the message appears unchanged on `out_data` in the same cycle.
- R4: Exactly ceil(L/32) input words are accepted for a length of L bits. `in_ready` stays low once they have been taken.
- R5: If r = L mod 32 is nonzero, the final message word keeps its upper r bits. Bit 31-r is forced to 1 and all lower bits are forced to 0.
- R6: If L is a multiple of 32, including L = 0, the word after the message is 0x80000000. For L = 0 this is the first output word, and no input is accepted.
- R7: The number of 512-bit blocks emitted is floor((L+64)/512)+1. Every word between the padding bit and the length words is zero.
- R8: Word 14 (counting from 0) of the final block carries bits 63:32 of the length. Word 15 carries bits 31:0.
- R9: `out_last_word` is high exactly on words whose index within the stream is 15 mod 16. `out_final_block` is high only on the very last word of the stream.
- R10: In the padding and length phases, while `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R11: The cycle after the final word is accepted, `idle` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a message; honoured only while idle |
| bit_len | input | 64 | Message length in bits, captured at start |
| idle | output | 1 | High when no message is in progress |
| in_data | input | 32 | Message word, earliest bit at bit 31 |
| in_valid | input | 1 | Message word present |
| in_ready | output | 1 | Message word may be taken |
| out_data | output | 32 | Padded word toward the core |
| out_valid | output | 1 | Padded word present |
| out_ready | input | 1 | Core accepts the word |
| out_last_word | output | 1 | Word is the 16th of its block |
| out_final_block | output | 1 | Word closes the final block |

## Verification
Every output word, its two flags and `in_ready` are combinational from the registered phase and the current inputs. Each result is therefore due in the same cycle as the handshake that produces it. The bench drives inputs just after a falling edge and samples one time unit later, well before the rising edge that commits the transfer. State changes appear one edge later. `idle` returns in the cycle after the final transfer, and the bench checks it at the falling edge that follows. A held word during a downstream stall is compared on the next cycle against the copy taken before the stall. Lengths 0 to 1100 are swept in full. Pseudo-random gaps on both handshakes cover every end-of-word offset and every spill case.

// File: rtl/sha_stream_padder.sv
module sha_stream_padder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] bit_len,
  output logic        idle,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [31:0] out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_last_word,
  output logic        out_final_block
);

  typedef enum logic [2:0] {S_IDLE, S_MSG, S_PAD, S_LHI, S_LLO} phase_t;

  phase_t      phase;
  logic [63:0] len_q;
  logic [63:0] rem_q;
  logic [3:0]  wcnt;
  logic        one_done;

  wire        partial  = rem_q < 64'd32;
  wire [4:0]  tail     = rem_q[4:0];
  wire [31:0] keep     = ~(32'hFFFF_FFFF >> tail);
  wire [31:0] msg_word = partial ? ((in_data & keep) | (32'h8000_0000 >> tail)) : in_data;
  wire        fire     = out_valid & out_ready;
  wire [63:0] rem_nxt  = partial ? 64'd0 : rem_q - 64'd32;
  wire [3:0]  wnext    = wcnt + 4'd1;
  wire        one_nxt  = one_done | (phase == S_PAD) | (phase == S_MSG && partial);

  assign idle            = (phase == S_IDLE);
  assign in_ready        = (phase == S_MSG) & out_ready;
  assign out_last_word   = (wcnt == 4'd15);
  assign out_final_block = (phase == S_LLO);

  always_comb begin
    out_valid = 1'b0;
    out_data  = 32'h0;
    case (phase)
      S_MSG: begin out_valid = in_valid; out_data = msg_word; end
      S_PAD: begin out_valid = 1'b1; out_data = one_done ? 32'h0 : 32'h8000_0000; end
      S_LHI: begin out_valid = 1'b1; out_data = len_q[63:32]; end
      S_LLO: begin out_valid = 1'b1; out_data = len_q[31:0]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      len_q    <= '0;
      rem_q    <= '0;
      wcnt     <= '0;
      one_done <= 1'b0;
    end else begin
      case (phase)
        S_IDLE: if (start) begin
          len_q    <= bit_len;
          rem_q    <= bit_len;
          wcnt     <= '0;
          one_done <= 1'b0;
          phase    <= (bit_len == 64'd0) ? S_PAD : S_MSG;
        end
        S_MSG, S_PAD: if (fire) begin
          wcnt     <= wnext;
          one_done <= one_nxt;
          if (phase == S_MSG) rem_q <= rem_nxt;
          if (one_nxt && wnext == 4'd14) phase <= S_LHI;
          else if (phase == S_MSG && rem_nxt == 64'd0) phase <= S_PAD;
        end
        S_LHI: if (fire) begin
          wcnt  <= wnext;
          phase <= S_LLO;
        end
        S_LLO: if (fire) begin
          wcnt  <= '0;
          phase <= S_IDLE;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!in_ready && !out_valid));

  assert_take_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  assert_rem_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (idle || rem_q <= $past(rem_q)));

  assert_final_on_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_final_block |-> out_last_word);

  assert_pad_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && phase != S_MSG) |=> (out_valid && $stable(out_data)));

  assert_back_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_final_block) |=> idle);

endmodule

// File: tb/sha_stream_padder_tb_top.sv
module sha_stream_padder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, start, idle, in_valid, in_ready, out_valid, out_ready;
  logic        out_last_word, out_final_block;
  logic [63:0] bit_len;
  logic [31:0] in_data, out_data;
  logic [15:0] lf = 16'hACE1;

  int checks = 0, fails = 0, cyc = 0;
  bit timeout = 0;

  sha_stream_padder dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_len(bit_len), .idle(idle),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last_word(out_last_word), .out_final_block(out_final_block));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) timeout = 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int L, input int i);
    return {8'hC3 ^ i[7:0], L[7:0], i[7:0] ^ 8'h5A, L[15:8] ^ 8'h77};
  endfunction

  function automatic logic [31:0] exp_word(input int L, input int i, input int nw, output string req);
    int base = i * 32;
    if (base + 32 <= L) begin req = "R3 data"; return gen(L, i); end
    if (base < L) begin
      int r = L - base;
      req = "R5 partial";
      return (gen(L, i) & ~(32'hFFFF_FFFF >> r)) | (32'h8000_0000 >> r);
    end
    if (base == L) begin req = "R6 pad bit"; return 32'h8000_0000; end
    if (i == nw - 2) begin req = "R8 len hi"; return 32'h0; end
    if (i == nw - 1) begin req = "R8 len lo"; return L; end
    req = "R7 zero fill";
    return 32'h0;
  endfunction

  task automatic run_msg(input int L);
    int nblk = (L + 64) / 512 + 1;
    int nw = nblk * 16;
    int nin = (L + 31) / 32;
    int ii = 0, oi = 0;
    bit stall = 0;
    logic [31:0] pdata = '0;
    string req;
    logic [31:0] ew;
    @(negedge clk);
    bit_len = L; start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0; bit_len = 64'hDEAD_BEEF_0000_1234;
    #1 chk(!idle, "R2 start taken", idle, 0);
    while (oi < nw && !timeout) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      in_valid  = lf[0] | lf[3];
      in_data   = gen(L, ii);
      out_ready = lf[5] | lf[7];
      start     = (oi == 3);
      #1;
      if (stall) chk(out_valid && out_data == pdata, "R10 hold", {31'b0, out_valid, out_data}, {32'h1, pdata});
      if (in_ready && ii >= nin) chk(0, "R4 enable after end", ii, nin);
      if (out_valid && out_ready) begin
        ew = exp_word(L, oi, nw, req);
        if (oi == 0 && L == 0) req = "R6 zero length";
        chk(out_data == ew, req, out_data, ew);
        chk(out_last_word == (oi % 16 == 15), "R9 last word", out_last_word, oi % 16 == 15);
        chk(out_final_block == (oi == nw - 1), "R9 final", out_final_block, oi == nw - 1);
        if (in_valid && in_ready) ii++;
        oi++;
      end
      stall = out_valid && !out_ready && (oi >= nin);
      pdata = out_data;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0;
    #1;
    chk(idle, "R11 idle again", idle, 1);
    chk(ii == nin, "R4 word count", ii, nin);
    chk(oi == nw, "R7 block count", oi, nw);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; bit_len = '0; in_data = '0; in_valid = 1'b1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(idle && !in_ready && !out_valid, "R1 reset state", {idle, in_ready, out_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(idle && !in_ready && !out_valid, "R1 idle quiet", {idle, in_ready, out_valid}, 3'b100);
    for (int L = 0; L <= 1100 && !timeout; L++) run_msg(L);
    if (timeout) chk(0, "watchdog", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule